// File: doc/BRIEF.md
# Configuration Request Packetizer

This block takes a single configuration-space read or write, described by target bus, device/function, byte address, access size, write data and a direction flag. It turns the access into a three-dword configuration request header followed by its data. The result leaves as 64-bit beats on a valid/ready transmit port, and each beat carries start and end flags. Before anything is sent, the request is screened. A probe of the bridge's own first base address register is refused as a bad register. A request to a device that cannot be present is refused as device-not-found. A refused request produces a response code and no beats.

For an accepted request, the block works out the byte enables and moves the write data onto its byte lanes. It picks a Type 0 header when the target is the root bus and a Type 1 header otherwise. The requester ID is formed from the root bus number and the bridge's own device/function. The root bus number is not fixed. The block holds it in a register and updates it from writes to the bridge's primary bus number register, so later requests are routed and labelled with the new value.

Top module: `cfg_tlp_packer`

## Requirements
- R1: After reset, req_ready is 1, tx_valid is 0, rsp_valid is 0 and the stored root bus number is 0, so the first packet's requester ID has 0x00 in bits 31:24 of header dword 1.
- R2: A request whose bus equals the root bus, with devfn 0x00 and byte address exactly 0x010, read or write, is refused with rsp_code 2 (bad register) and no beat is sent.
- R3: On the root bus, a request with a nonzero device number (devfn bits 7:3) is refused with rsp_code 1. A request to any other bus is refused with rsp_code 1 unless link_state equals L0_CODE. R2 is checked before R3.
- R4: The header type byte is 0x04 for a Type 0 read, 0x44 for a Type 0 write, 0x05 for a Type 1 read and 0x45 for a Type 1 write. Type 0 is used exactly when the bus equals the stored root bus number.
- R5: Header dword 0 is {type byte, 24'h000001}. Dword 1 is {root bus, RP_DEVFN, tag, byte enables}, with tag 0x1D for reads and 0x10 for writes. Dword 2 is {bus, devfn, 16-bit byte address with bits 1:0 cleared}.
- R6: With size code 0 = 1 byte, 1 = 2 bytes and 2 or 3 = 4 bytes, and a = addr[1:0], the byte enables are 0x1<<a, 0x3<<a or 0xF. The write data is masked to the access size and then shifted left by 8*a. Read data is zero.
- R7: Beat 1 is {dword1, dword0} (low dword in bits 31:0) with tx_sop set. A write with addr[2] = 0 sends beat 2 = {data, dword2} with tx_eop set. All other requests send beat 2 = {0, dword2} with no flag, then beat 3 = {0, data} with tx_eop set.
- R8: A request is taken only when req_ready is 1, which holds only while no packet is in flight. A beat stays unchanged while tx_ready is 0. req_ready returns in the cycle after the end beat is accepted.
- R9: An accepted write on the root bus to any byte of the dword at address 0x018 loads bits 7:0 of its lane-positioned data into the root bus number. The new value applies to the next request.
- R10: Every taken request produces rsp_valid for one cycle in the cycle after it is taken, with rsp_code 0 when a packet follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_devfn | input | 8 | Target device (7:3) and function (2:0) |
| req_addr | input | ADDR_W | Configuration byte address |
| req_size | input | 2 | 0 byte, 1 two bytes, 2/3 dword |
| req_wdata | input | 32 | Write value, right-aligned |
| link_state | input | LINK_W | Current link training state code |
| rsp_valid | output | 1 | Response for the request taken last cycle |
| rsp_code | output | 2 | 0 sent, 1 device not found, 2 bad register |
| tx_valid | output | 1 | Beat present |
| tx_ready | input | 1 | Beat taken by sink |
| tx_data | output | 64 | Beat payload |
| tx_sop | output | 1 | First beat of packet |
| tx_eop | output | 1 | Last beat of packet |

## Verification
The bench overrides RP_DEVFN to 0x08, so the requester ID has a nonzero low byte and a swap of the requester fields would show. It keeps L0_CODE at 0x11, and by toggling link_state between that code and another value it reaches both the accepted and the refused outcome for off-root buses. Writing the primary bus register moves the root bus to 3. Bus 0 then becomes an off-root target, so one bench covers Type 0 and Type 1 selection and the filtering that follows from the learned number.

// File: rtl/cfg_tlp_pkg.sv
package cfg_tlp_pkg;

   typedef enum logic [1:0] {
      RSP_SENT   = 2'd0,
      RSP_NODEV  = 2'd1,
      RSP_BADREG = 2'd2
   } rsp_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_HEAD  = 2'd1,
      ST_MID   = 2'd2,
      ST_TAIL  = 2'd3
   } beat_st_e;

   localparam logic [7:0] TYPE_BASE = 8'h04;
   localparam logic [7:0] TYPE_WR   = 8'h40;
   localparam logic [7:0] TYPE_FAR  = 8'h01;

   function automatic logic [7:0] type_byte(input logic is_wr, input logic far);
      return TYPE_BASE | (is_wr ? TYPE_WR : 8'h00) | (far ? TYPE_FAR : 8'h00);
   endfunction

endpackage

// File: rtl/cfg_req_filter.sv
module cfg_req_filter
   import cfg_tlp_pkg::*;
#(
   parameter int          ADDR_W    = 12,
   parameter int          LINK_W    = 5,
   parameter logic [LINK_W-1:0] L0_CODE   = 5'h11,
   parameter logic [ADDR_W-1:0] HIDE_ADDR = 12'h010
) (
   input  logic [7:0]        bus,
   input  logic [7:0]        devfn,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        root_bus,
   input  logic [LINK_W-1:0] link_state,
   output logic [1:0]        verdict
);
   logic on_root, hidden, absent;

   assign on_root = (bus == root_bus);
   assign hidden  = on_root && (devfn == 8'h00) && (addr == HIDE_ADDR);
   assign absent  = on_root ? (devfn[7:3] != 5'd0) : (link_state != L0_CODE);

   always_comb begin
      if (hidden)      verdict = RSP_BADREG;
      else if (absent) verdict = RSP_NODEV;
      else             verdict = RSP_SENT;
   end
endmodule

// File: rtl/cfg_hdr_build.sv
module cfg_hdr_build
   import cfg_tlp_pkg::*;
#(
   parameter int         ADDR_W   = 12,
   parameter logic [7:0] RP_DEVFN = 8'h00,
   parameter logic [7:0] RD_TAG   = 8'h1D,
   parameter logic [7:0] WR_TAG   = 8'h10
) (
   input  logic              is_wr,
   input  logic [7:0]        bus,
   input  logic [7:0]        devfn,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic [31:0]       wdata,
   input  logic [7:0]        root_bus,
   output logic [31:0]       hdr0,
   output logic [31:0]       hdr1,
   output logic [31:0]       hdr2,
   output logic [31:0]       lane_data,
   output logic              two_beat
);
   localparam int LANES = 4;

   logic [1:0]       lane_sel;
   logic [LANES-1:0] be_lo;
   logic             be_spill;
   logic [31:0]      sized;
   logic [7:0]       be_field;

   assign lane_sel = addr[1:0];

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign be_lo[i] = size[1]
                      | ((size == 2'd1) && ((lane_sel == 2'(i)) ||
                                            ((3'(lane_sel) + 3'd1) == 3'(i))))
                      | ((size == 2'd0) && (lane_sel == 2'(i)));
      assign sized[8*i +: 8] = (i == 0 || size[1] || (i == 1 && size == 2'd1))
                               ? wdata[8*i +: 8] : 8'h00;
   end

   assign be_spill  = (size == 2'd1) && (lane_sel == 2'd3);
   assign be_field  = {3'b000, be_spill, be_lo};
   assign lane_data = is_wr ? (sized << {lane_sel, 3'b000}) : 32'h0;

   assign hdr0     = {type_byte(is_wr, bus != root_bus), 24'h000001};
   assign hdr1     = {root_bus, RP_DEVFN, (is_wr ? WR_TAG : RD_TAG), be_field};
   assign hdr2     = {bus, devfn, 16'({addr[ADDR_W-1:2], 2'b00})};
   assign two_beat = is_wr && !addr[2];
endmodule

// File: rtl/cfg_beat_seq.sv
module cfg_beat_seq
   import cfg_tlp_pkg::*;
#(
   parameter int BEAT_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [31:0]       hdr0,
   input  logic [31:0]       hdr1,
   input  logic [31:0]       hdr2,
   input  logic [31:0]       lane_data,
   input  logic              two_beat,
   input  logic              tx_ready,
   output logic              idle,
   output logic              tx_valid,
   output logic [BEAT_W-1:0] tx_data,
   output logic              tx_sop,
   output logic              tx_eop
);
   localparam int HALF = BEAT_W / 2;

   beat_st_e   st;
   logic [31:0] h0_q, h1_q, h2_q, d_q;
   logic        short_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         h0_q    <= '0;
         h1_q    <= '0;
         h2_q    <= '0;
         d_q     <= '0;
         short_q <= 1'b0;
      end else begin
         case (st)
            ST_IDLE: if (load) begin
               st      <= ST_HEAD;
               h0_q    <= hdr0;
               h1_q    <= hdr1;
               h2_q    <= hdr2;
               d_q     <= lane_data;
               short_q <= two_beat;
            end
            ST_HEAD: if (tx_ready) st <= ST_MID;
            ST_MID:  if (tx_ready) st <= short_q ? ST_IDLE : ST_TAIL;
            default: if (tx_ready) st <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      tx_sop  = 1'b0;
      tx_eop  = 1'b0;
      tx_data = '0;
      case (st)
         ST_HEAD: begin
            tx_sop  = 1'b1;
            tx_data = {HALF'(h1_q), HALF'(h0_q)};
         end
         ST_MID: begin
            tx_eop  = short_q;
            tx_data = {(short_q ? HALF'(d_q) : HALF'(0)), HALF'(h2_q)};
         end
         ST_TAIL: begin
            tx_eop  = 1'b1;
            tx_data = {HALF'(0), HALF'(d_q)};
         end
         default: ;
      endcase
   end

   assign idle     = (st == ST_IDLE);
   assign tx_valid = !idle;
endmodule

// File: rtl/cfg_tlp_packer.sv
module cfg_tlp_packer
   import cfg_tlp_pkg::*;
#(
   parameter int                ADDR_W     = 12,
   parameter int                LINK_W     = 5,
   parameter logic [LINK_W-1:0] L0_CODE    = 5'h11,
   parameter logic [7:0]        RP_DEVFN   = 8'h00,
   parameter logic [ADDR_W-1:0] HIDE_ADDR  = 12'h010,
   parameter logic [ADDR_W-1:0] PRIBUS_ADDR = 12'h018,
   parameter logic [7:0]        RD_TAG     = 8'h1D,
   parameter logic [7:0]        WR_TAG     = 8'h10,
   parameter int                BEAT_W     = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [7:0]        req_bus,
   input  logic [7:0]        req_devfn,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [31:0]       req_wdata,
   input  logic [LINK_W-1:0] link_state,
   output logic              rsp_valid,
   output logic [1:0]        rsp_code,
   output logic              tx_valid,
   input  logic              tx_ready,
   output logic [BEAT_W-1:0] tx_data,
   output logic              tx_sop,
   output logic              tx_eop
);
   localparam int PRI_DW = ADDR_W - 2;

   initial begin
      if (ADDR_W < 3 || ADDR_W > 16)
         $error("ADDR_W must lie in 3..16 to fit the header offset field");
      if (BEAT_W != 64)
         $error("BEAT_W must be 64: two header dwords per beat");
      if (LINK_W < 1)
         $error("LINK_W must be positive");
   end

   logic [7:0]  root_q;
   logic [1:0]  verdict;
   logic        take, send;
   logic [31:0] hdr0, hdr1, hdr2, lane_data;
   logic        two_beat, idle;

   cfg_req_filter #(
      .ADDR_W(ADDR_W), .LINK_W(LINK_W), .L0_CODE(L0_CODE), .HIDE_ADDR(HIDE_ADDR)
   ) u_filter (
      .bus(req_bus), .devfn(req_devfn), .addr(req_addr),
      .root_bus(root_q), .link_state(link_state), .verdict(verdict)
   );

   cfg_hdr_build #(
      .ADDR_W(ADDR_W), .RP_DEVFN(RP_DEVFN), .RD_TAG(RD_TAG), .WR_TAG(WR_TAG)
   ) u_hdr (
      .is_wr(req_write), .bus(req_bus), .devfn(req_devfn), .addr(req_addr),
      .size(req_size), .wdata(req_wdata), .root_bus(root_q),
      .hdr0(hdr0), .hdr1(hdr1), .hdr2(hdr2), .lane_data(lane_data),
      .two_beat(two_beat)
   );

   cfg_beat_seq #(.BEAT_W(BEAT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .load(send),
      .hdr0(hdr0), .hdr1(hdr1), .hdr2(hdr2), .lane_data(lane_data),
      .two_beat(two_beat), .tx_ready(tx_ready), .idle(idle),
      .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop)
   );

   assign req_ready = idle;
   assign take      = req_valid && idle;
   assign send      = take && (verdict == RSP_SENT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         root_q    <= 8'h00;
         rsp_valid <= 1'b0;
         rsp_code  <= RSP_SENT;
      end else begin
         rsp_valid <= take;
         if (take) rsp_code <= verdict;
         if (send && req_write && (req_bus == root_q) &&
             (req_addr[ADDR_W-1:2] == PRIBUS_ADDR[ADDR_W-1:2]))
            root_q <= lane_data[7:0];
      end
   end
endmodule

// File: rtl/cfg_tlp_packer_chk.sv
module cfg_tlp_packer_chk #(
   parameter int BEAT_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [1:0]        rsp_code,
   input logic              tx_valid,
   input logic              tx_ready,
   input logic [BEAT_W-1:0] tx_data,
   input logic              tx_sop,
   input logic              tx_eop
);
   // R8
   beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) &&
                                   $stable(tx_sop) && $stable(tx_eop)));
   // R8
   busy_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !req_ready);
   // R8
   eop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_eop) |=> (req_ready && !tx_valid));
   // R2
   refuse_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code != 2'd0) |-> !tx_valid);
   // R10
   sent_has_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_code == 2'd0) |-> (tx_valid && tx_sop));
   // R7
   markers_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |-> !(tx_sop && tx_eop));
   // R10
   rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid && req_ready));
endmodule

bind cfg_tlp_packer cfg_tlp_packer_chk #(.BEAT_W(BEAT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .rsp_valid(rsp_valid), .rsp_code(rsp_code), .tx_valid(tx_valid),
   .tx_ready(tx_ready), .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop)
);

// File: tb/sim_cfg_tlp_packer.sv
module sim_cfg_tlp_packer;
   localparam int CLK_PERIOD = 10;
   localparam logic [4:0] L0 = 5'h11;
   localparam logic [7:0] OWN_DF = 8'h08;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [7:0]  req_bus = '0, req_devfn = '0;
   logic [11:0] req_addr = '0;
   logic [1:0]  req_size = '0;
   logic [31:0] req_wdata = '0;
   logic [4:0]  link_state = 5'h00;
   logic        tx_ready = 1'b0;
   logic        req_ready, rsp_valid, tx_valid, tx_sop, tx_eop;
   logic [1:0]  rsp_code;
   logic [63:0] tx_data;

   int errors = 0, checks = 0;
   logic [63:0] bd [4];
   logic        bs [4], bp [4];
   int          nb;

   always #(CLK_PERIOD/2) clk = ~clk;

   cfg_tlp_packer #(.L0_CODE(L0), .RP_DEVFN(OWN_DF)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_bus(req_bus), .req_devfn(req_devfn),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .link_state(link_state), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
      .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
      .tx_sop(tx_sop), .tx_eop(tx_eop)
   );

   task automatic chk(input logic ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic w, input logic [7:0] b, input logic [7:0] df,
                        input logic [11:0] a, input logic [1:0] sz,
                        input logic [31:0] d, input logic [1:0] code,
                        input string req);
      @(negedge clk);
      req_write = w; req_bus = b; req_devfn = df; req_addr = a;
      req_size = sz; req_wdata = d; req_valid = 1'b1;
      @(posedge clk); #1 req_valid = 1'b0;
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_code === code, req,
          {62'(0), rsp_valid, 1'b0} | 64'(rsp_code), 64'(code));
   endtask

   task automatic get_pkt(input int stall);
      logic [63:0] first;
      logic done = 1'b0;
      nb = 0;
      first = tx_data;
      for (int k = 0; k < 40 && !done; k++) begin
         @(negedge clk);
         tx_ready = (k >= stall);
         if (k < stall)
            chk(tx_valid && tx_sop && tx_data == first && !req_ready,
                "R8 beat held under back-pressure", tx_data, first);
         if (tx_valid && tx_ready) begin
            if (nb < 4) begin bd[nb] = tx_data; bs[nb] = tx_sop; bp[nb] = tx_eop; end
            nb++;
            done = tx_eop;
         end
         @(posedge clk); #1;
      end
      tx_ready = 1'b0;
      @(negedge clk);
      chk(req_ready === 1'b1 && tx_valid === 1'b0, "R8 idle after end beat",
          64'(req_ready), 64'd1);
   endtask

   task automatic exp_pkt(input logic [31:0] h0, input logic [31:0] h1,
                          input logic [31:0] h2, input logic [31:0] d,
                          input logic two, input string req);
      int en = two ? 2 : 3;
      chk(nb == en, {req, " R7 beat count"}, 64'(nb), 64'(en));
      if (nb == en) begin
         chk(bd[0] == {h1, h0} && bs[0] && !bp[0], {req, " beat 1"}, bd[0], {h1, h0});
         if (two)
            chk(bd[1] == {d, h2} && !bs[1] && bp[1], {req, " R7 beat 2 short"},
                bd[1], {d, h2});
         else begin
            chk(bd[1] == {32'h0, h2} && !bs[1] && !bp[1], {req, " R7 beat 2"},
                bd[1], {32'h0, h2});
            chk(bd[2] == {32'h0, d} && !bs[2] && bp[2], {req, " R7 beat 3"},
                bd[2], {32'h0, d});
         end
      end
   endtask

   task automatic quiet(input string req);
      for (int k = 0; k < 3; k++) begin
         @(negedge clk);
         chk(!tx_valid && req_ready, req, 64'(tx_valid), 64'd0);
      end
   endtask

   task automatic t_reset;
      @(negedge clk);
      chk(req_ready === 1'b1 && tx_valid === 1'b0 && rsp_valid === 1'b0,
          "R1 reset outputs", {61'(0), req_ready, tx_valid, rsp_valid}, 64'b100);
   endtask

   task automatic t_type0_read;
      issue(1'b0, 8'h00, 8'h00, 12'h004, 2'd2, 32'hFFFF_FFFF, 2'd0, "R10 read sent");
      get_pkt(0);
      // R1 R4 R5 R6: root 0 in requester ID, read tag, full enables, zero data
      exp_pkt(32'h0400_0001, {8'h00, OWN_DF, 8'h1D, 8'h0F}, 32'h0000_0004,
              32'h0, 1'b0, "R4 R5 type0 read");
   endtask

   task automatic t_byte_write;
      issue(1'b1, 8'h00, 8'h00, 12'h00D, 2'd0, 32'h1234_56AB, 2'd0, "R10 byte write");
      get_pkt(0);
      exp_pkt(32'h4400_0001, {8'h00, OWN_DF, 8'h10, 8'h02}, 32'h0000_000C,
              32'h0000_AB00, 1'b0, "R6 byte write lane 1");
   endtask

   task automatic t_half_write;
      issue(1'b1, 8'h00, 8'h00, 12'h00A, 2'd1, 32'h5555_BEEF, 2'd0, "R10 half write");
      get_pkt(0);
      exp_pkt(32'h4400_0001, {8'h00, OWN_DF, 8'h10, 8'h0C}, 32'h0000_0008,
              32'hBEEF_0000, 1'b1, "R6 R7 half write aligned");
   endtask

   task automatic t_hidden;
      issue(1'b0, 8'h00, 8'h00, 12'h010, 2'd2, 32'h0, 2'd2, "R2 hidden read");
      quiet("R2 no beats on hidden read");
      issue(1'b1, 8'h00, 8'h00, 12'h010, 2'd2, 32'hFFFF_FFFF, 2'd2, "R2 hidden write");
      quiet("R2 no beats on hidden write");
   endtask

   task automatic t_absent;
      issue(1'b0, 8'h00, 8'h08, 12'h000, 2'd2, 32'h0, 2'd1, "R3 root dev 1");
      quiet("R3 no beats root dev 1");
      link_state = 5'h03;
      issue(1'b0, 8'h05, 8'h00, 12'h000, 2'd2, 32'h0, 2'd1, "R3 link down");
      quiet("R3 no beats link down");
   endtask

   task automatic t_type1;
      link_state = L0;
      issue(1'b0, 8'h05, 8'h10, 12'h100, 2'd2, 32'h0, 2'd0, "R3 link up accepted");
      get_pkt(0);
      exp_pkt(32'h0500_0001, {8'h00, OWN_DF, 8'h1D, 8'h0F}, 32'h0510_0100,
              32'h0, 1'b0, "R4 type1 read");
      issue(1'b1, 8'h05, 8'h10, 12'h100, 2'd2, 32'hCAFE_F00D, 2'd0, "R10 type1 write");
      // R8: offer another request while busy, it must not be taken
      @(negedge clk);
      req_bus = 8'h00; req_devfn = 8'h00; req_addr = 12'h0; req_valid = 1'b1;
      @(posedge clk); #1 req_valid = 1'b0;
      @(negedge clk);
      chk(rsp_valid === 1'b0 && tx_valid && tx_sop, "R8 no take while busy",
          64'(rsp_valid), 64'd0);
      get_pkt(3);
      exp_pkt(32'h4500_0001, {8'h00, OWN_DF, 8'h10, 8'h0F}, 32'h0510_0100,
              32'hCAFE_F00D, 1'b1, "R4 type1 write");
   endtask

   task automatic t_rootbus;
      issue(1'b1, 8'h00, 8'h00, 12'h018, 2'd2, 32'h0000_0203, 2'd0, "R9 primary write");
      get_pkt(0);
      link_state = 5'h00;
      issue(1'b0, 8'h03, 8'h00, 12'h000, 2'd2, 32'h0, 2'd0, "R9 new root accepted");
      get_pkt(0);
      exp_pkt(32'h0400_0001, {8'h03, OWN_DF, 8'h1D, 8'h0F}, 32'h0300_0000,
              32'h0, 1'b0, "R9 type0 on learned root");
      issue(1'b0, 8'h00, 8'h00, 12'h000, 2'd2, 32'h0, 2'd1, "R9 old root now off-root");
      quiet("R9 no beats old root link down");
      link_state = L0;
      issue(1'b0, 8'h00, 8'h00, 12'h010, 2'd2, 32'h0, 2'd0, "R2 R9 addr 0x10 off-root sent");
      get_pkt(0);
      exp_pkt(32'h0500_0001, {8'h03, OWN_DF, 8'h1D, 8'h0F}, 32'h0000_0010,
              32'h0, 1'b0, "R4 type1 to old root");
   endtask

   initial begin
      #(CLK_PERIOD * 5000);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      t_reset();
      t_type0_read();
      t_byte_write();
      t_half_write();
      t_hidden();
      t_absent();
      t_type1();
      t_rootbus();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule